// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit-side sequencer of a DMA engine. Software places frame descriptors in memory as a circular linked list and sets a per-descriptor ownership flag on each one that is ready to send. It then pulses a start input. The walker fetches descriptors one word at a time through a simple memory port, starting at the address held in its current-descriptor pointer. For every owned descriptor it emits one record that gives the buffer address and the length. It hands the descriptor back by clearing the ownership flag with a write-back, then follows the next-pointer.

The walk stops at the first descriptor whose ownership flag is clear. The pointer then still names that descriptor, so the next start resumes exactly there and does not rescan from the list head. Ready descriptors that wrap past the end of the ring are therefore sent without loss. When a walk ends, a transmit-done status bit is set. An interrupt line is raised whenever a status bit and its enable bit are both set.

Moving payload bytes, framing and the line interface belong to other blocks. The record stream feeds a payload mover that holds at most 2048 bytes per packet.

Top module: `txring_walker`

## Requirements
- R1: After reset, busy, irq, int_status, rec_valid and mem_req are all 0, and cur_ptr is 0.
- R2: A start pulse while idle begins the walk at the descriptor address held in cur_ptr. The pointer keeps its value between walks and can be loaded by software while idle.
- R3: A descriptor is four 32-bit words at byte offsets +0 (status, ownership flag at bit 31), +4 (size word), +8 (buffer address) and +12 (next-descriptor address). The walk consumes descriptors while the ownership flag is 1 and stops at the first descriptor where it is 0.
- R4: For each consumed descriptor, one rec_valid pulse is emitted. It carries rec_addr equal to the word at +8 and rec_len equal to bits 10:0 of the word at +4; upper bits of that word have no effect.
- R5: After each consumed descriptor, cur_ptr takes the value of its next-descriptor word. When the walk stops, cur_ptr names the unowned descriptor that ended it, so a ready run that wraps past the ring tail is sent in ring order.
- R6: Each consumed descriptor's status word is written back to the same address with bit 31 cleared and all other bits unchanged. This happens before the next descriptor is fetched.
- R7: When a walk stops, int_status bit 0 (transmit done) is set, even when no descriptor was consumed.
- R8: irq is 1 exactly when int_status AND the interrupt enable register is nonzero. The enable register is written with int_en_wr/int_en_wdata.
- R9: int_status bits are write-1-to-clear through int_clr_wr/int_clr_wdata. A set in the same cycle as a clear wins.
- R10: A start pulse or a cur_ptr write that arrives while busy is ignored. The walk proceeds as if neither occurred.
- R11: The memory port has at most one read outstanding: a read request is never followed directly by another request. Read data returns with mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse |
| cur_wr | input | 1 | Load strobe for the current-descriptor pointer |
| cur_wdata | input | AW | Value to load into the pointer |
| cur_ptr | output | AW | Current-descriptor pointer |
| int_en_wr | input | 1 | Write strobe for the interrupt enable register |
| int_en_wdata | input | INT_W | Interrupt enable value |
| int_clr_wr | input | 1 | Write strobe for the interrupt status clear |
| int_clr_wdata | input | INT_W | Write-1-to-clear mask |
| int_status | output | INT_W | Interrupt status (bit 0 transmit done) |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rec_valid | output | 1 | Buffer record valid |
| rec_addr | output | AW | Buffer address |
| rec_len | output | LEN_W | Buffer length in bytes |

## Verification
The state that matters is the saved pointer. If it is wrong after a walk, the next start fetches the wrong descriptor, and the error shows in the first record and in cur_ptr as soon as that walk ends. A wrong ownership decision shows within one descriptor as a missing or extra record. A lost write-back shows in memory, and on a full-ring walk it shows as the walker going around the ring again. The bench builds rings whose ready run wraps past the tail, runs walks that find nothing ready, and checks the record stream, memory contents and the pointer after each walk.

// File: rtl/txr_pkg.sv
// Shared types and descriptor layout constants for the transmit ring walker.
// Assumes descriptors of four 32-bit words, byte addressed.
package txr_pkg;
    localparam int DW      = 32;
    localparam int OWN_BIT = 31;
    localparam int INT_W   = 1;
    localparam int INT_DONE = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPT,
        ST_WBACK,
        ST_FIN
    } walk_state_t;
endpackage

// File: rtl/txr_seq.sv
// Walk sequencer: fetches descriptor words one at a time, emits a record per
// owned descriptor, writes back the cleared status word and follows the link.
// Assumes a memory that answers each read with mem_rvalid some cycles later
// and accepts writes in the request cycle.
module txr_seq
    import txr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] start_ptr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rec_valid,
    output logic [AW-1:0] rec_addr,
    output logic [LEN_W-1:0] rec_len,
    output logic          busy,
    output logic          done,
    output logic          ptr_ld,
    output logic [AW-1:0] ptr_val
);
    localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_BIT;

    walk_state_t      state;
    logic [1:0]       widx;
    logic [AW-1:0]    base;
    logic [DW-1:0]    w_stat;
    logic [LEN_W-1:0] w_len;
    logic [AW-1:0]    w_buf;
    logic [AW-1:0]    w_nxt;

    // State, word index and captured descriptor fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            widx   <= '0;
            base   <= '0;
            w_stat <= '0;
            w_len  <= '0;
            w_buf  <= '0;
            w_nxt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        base  <= start_ptr;
                        widx  <= '0;
                        state <= ST_READ;
                    end
                end
                ST_READ: state <= ST_CAPT;
                ST_CAPT: begin
                    if (mem_rvalid) begin
                        case (widx)
                            2'd0: begin
                                w_stat <= mem_rdata;
                                if (mem_rdata[OWN_BIT]) begin
                                    widx  <= 2'd1;
                                    state <= ST_READ;
                                end else begin
                                    state <= ST_FIN;
                                end
                            end
                            2'd1: begin
                                w_len <= mem_rdata[LEN_W-1:0];
                                widx  <= 2'd2;
                                state <= ST_READ;
                            end
                            2'd2: begin
                                w_buf <= mem_rdata[AW-1:0];
                                widx  <= 2'd3;
                                state <= ST_READ;
                            end
                            default: begin
                                w_nxt <= mem_rdata[AW-1:0];
                                state <= ST_WBACK;
                            end
                        endcase
                    end
                end
                ST_WBACK: begin
                    base  <= w_nxt;
                    widx  <= '0;
                    state <= ST_READ;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port, record and pointer-update outputs decoded from the state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base + {{(AW-4){1'b0}}, widx, 2'b00};
        mem_wdata = w_stat & ~OWN_MASK;
        rec_valid = 1'b0;
        ptr_ld    = 1'b0;
        if (state == ST_READ) begin
            mem_req = 1'b1;
        end else if (state == ST_WBACK) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = base;
            rec_valid = 1'b1;
            ptr_ld    = 1'b1;
        end
    end

    assign rec_addr = w_buf;
    assign rec_len  = w_len;
    assign ptr_val  = w_nxt;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
endmodule

// File: rtl/txr_ptr.sv
// Current-descriptor pointer: loaded by software while idle, advanced by the
// walker after every consumed descriptor. Assumes walker updates win.
module txr_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          sw_wr,
    input  logic [AW-1:0] sw_data,
    input  logic          hw_ld,
    input  logic [AW-1:0] hw_data,
    output logic [AW-1:0] ptr
);
    // Pointer register with walker priority and a software load gated by idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (hw_ld)
            ptr <= hw_data;
        else if (sw_wr && !busy)
            ptr <= sw_data;
    end
endmodule

// File: rtl/txr_irq.sv
// Interrupt status (write-1-to-clear, set wins) and enable registers, and the
// combined request line. Assumes set inputs are single-cycle events.
module txr_irq #(
    parameter int INT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [INT_W-1:0] clr_data,
    input  logic             en_wr,
    input  logic [INT_W-1:0] en_data,
    output logic [INT_W-1:0] status,
    output logic [INT_W-1:0] enable,
    output logic             irq
);
    logic [INT_W-1:0] clr_mask;

    // Clear mask is only live during a clear write.
    always_comb clr_mask = clr_wr ? clr_data : '0;

    // Status bits: clear first, then set so a coincident event is not lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_mask) | set_vec;
    end

    // Enable register written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (en_wr)
            enable <= en_data;
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/txring_walker.sv
// Top of the transmit descriptor ring walker: sequencer, saved pointer and
// interrupt registers. Assumes AW between 5 and 32.
module txring_walker
    import txr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             cur_wr,
    input  logic [AW-1:0]    cur_wdata,
    output logic [AW-1:0]    cur_ptr,
    input  logic             int_en_wr,
    input  logic [INT_W-1:0] int_en_wdata,
    input  logic             int_clr_wr,
    input  logic [INT_W-1:0] int_clr_wdata,
    output logic [INT_W-1:0] int_status,
    output logic             irq,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             rec_valid,
    output logic [AW-1:0]    rec_addr,
    output logic [LEN_W-1:0] rec_len
);
    logic             walk_done;
    logic             ptr_ld;
    logic [AW-1:0]    ptr_val;
    logic [INT_W-1:0] set_vec;
    logic [INT_W-1:0] int_en_q;

    // Map the walk-done event onto its status bit.
    always_comb begin
        set_vec           = '0;
        set_vec[INT_DONE] = walk_done;
    end

    txr_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .start_ptr  (cur_ptr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rec_valid  (rec_valid),
        .rec_addr   (rec_addr),
        .rec_len    (rec_len),
        .busy       (busy),
        .done       (walk_done),
        .ptr_ld     (ptr_ld),
        .ptr_val    (ptr_val)
    );

    txr_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .sw_wr   (cur_wr),
        .sw_data (cur_wdata),
        .hw_ld   (ptr_ld),
        .hw_data (ptr_val),
        .ptr     (cur_ptr)
    );

    txr_irq #(.INT_W(INT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (int_clr_wr),
        .clr_data (int_clr_wdata),
        .en_wr    (int_en_wr),
        .en_data  (int_en_wdata),
        .status   (int_status),
        .enable   (int_en_q),
        .irq      (irq)
    );
endmodule

// File: rtl/txring_walker_chk.sv
// Property checker for the ring walker, bound to every instance of the top.
module txring_walker_chk
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cur_wr,
    input logic [AW-1:0]    cur_ptr,
    input logic             mem_req,
    input logic             mem_we,
    input logic [DW-1:0]    mem_wdata,
    input logic             rec_valid,
    input logic [INT_W-1:0] int_status,
    input logic [INT_W-1:0] int_en_q,
    input logic             irq
);
    // R3: records only appear during a walk
    p_rec_in_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> busy);

    // R6: every write-back drops the ownership flag, and a record goes with it
    p_wb_drops_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!mem_wdata[OWN_BIT] && rec_valid));

    // R2: pointer holds while idle without a software load
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cur_wr) |=> $stable(cur_ptr));

    // R7: the end of a walk leaves the done bit set
    p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> int_status[INT_DONE]);

    // R8: request line follows status and enable
    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(int_status & int_en_q)));

    // R11: no back-to-back request after a read
    p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);
endmodule

bind txring_walker txring_walker_chk #(.AW(AW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cur_wr     (cur_wr),
    .cur_ptr    (cur_ptr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .rec_valid  (rec_valid),
    .int_status (int_status),
    .int_en_q   (int_en_q),
    .irq        (irq)
);

// File: tb/test_txring_walker.sv
module test_txring_walker;
    localparam int AW    = 32;
    localparam int LEN_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic cur_wr = 1'b0;
    logic [AW-1:0] cur_wdata = '0;
    logic [AW-1:0] cur_ptr;
    logic int_en_wr = 1'b0;
    logic [0:0] int_en_wdata = '0;
    logic int_clr_wr = 1'b0;
    logic [0:0] int_clr_wdata = '0;
    logic [0:0] int_status;
    logic irq, busy, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic rec_valid;
    logic [AW-1:0] rec_addr;
    logic [LEN_W-1:0] rec_len;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] mem [0:255];
    logic [AW+LEN_W-1:0] exp_q [$];
    bit finished = 0;

    always #2 clk = ~clk;

    txring_walker #(.AW(AW), .LEN_W(LEN_W)) i_txring_walker (
        .clk(clk), .rst_n(rst_n), .go(go), .cur_wr(cur_wr), .cur_wdata(cur_wdata),
        .cur_ptr(cur_ptr), .int_en_wr(int_en_wr), .int_en_wdata(int_en_wdata),
        .int_clr_wr(int_clr_wr), .int_clr_wdata(int_clr_wdata),
        .int_status(int_status), .irq(irq), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rec_valid(rec_valid),
        .rec_addr(rec_addr), .rec_len(rec_len)
    );

    // Descriptor memory model: reads answer one cycle later
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_we;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_req && mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected records and compare
    always @(negedge clk) begin
        if (rst_n && rec_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected record", {rec_addr, rec_len}, 0);
            end else begin
                logic [AW+LEN_W-1:0] e;
                e = exp_q.pop_front();
                check({rec_addr, rec_len} == e, "R4 record", {rec_addr, rec_len}, e);
            end
        end
    end

    task automatic put_desc(input int a, input bit own, input logic [31:0] s2,
                            input logic [31:0] buff, input logic [31:0] nxt);
        mem[a/4]     = {own, 31'h0000_0A5A};
        mem[a/4 + 1] = s2;
        mem[a/4 + 2] = buff;
        mem[a/4 + 3] = nxt;
    endtask

    // Driver: push the expected record of descriptor at byte address a
    task automatic expect_desc(input int a);
        exp_q.push_back({mem[a/4 + 2][AW-1:0], mem[a/4 + 1][LEN_W-1:0]});
    endtask

    // Build a 4-entry ring at 0x000..0x030 with the given ownership mask
    task automatic build_ring(input logic [3:0] own);
        for (int i = 0; i < 4; i++)
            put_desc(i*16, own[i], 32'h100 + i*32'h11, 32'h8000 + i*32'h400,
                     ((i+1)%4)*16);
    endtask

    task automatic set_ptr(input logic [AW-1:0] v);
        @(negedge clk); cur_wr = 1; cur_wdata = v;
        @(negedge clk); cur_wr = 0;
    endtask

    task automatic run_walk();
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); int_clr_wr = 1; int_clr_wdata = 1'b1;
        @(negedge clk); int_clr_wr = 0;
    endtask

    task automatic q_empty(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, irq, int_status, rec_valid, mem_req} == 0, "R1 outputs",
              {busy, irq, int_status, rec_valid, mem_req}, 0);
        check(cur_ptr == 0, "R1 cur_ptr", cur_ptr, 0);
        rst_n = 1;
        @(negedge clk);

        // R2/R3/R5/R6: two ready descriptors from head
        build_ring(4'b0011);
        expect_desc(0); expect_desc(16);
        run_walk();
        q_empty("R3 records walk1");
        check(cur_ptr == 32'h20, "R5 ptr after walk1", cur_ptr, 32'h20);
        check(mem[0] == 32'h0000_0A5A, "R6 writeback d0", mem[0], 32'h0000_0A5A);
        check(mem[4] == 32'h0000_0A5A, "R6 writeback d1", mem[4], 32'h0000_0A5A);
        check(int_status == 1'b1, "R7 done set", int_status, 1);
        check(irq == 0, "R8 irq masked", irq, 0);

        // R8: enable, then R9: clear
        @(negedge clk); int_en_wr = 1; int_en_wdata = 1'b1;
        @(negedge clk); int_en_wr = 0;
        check(irq == 1, "R8 irq enabled", irq, 1);
        clear_irq();
        check(int_status == 0, "R9 w1c", int_status, 0);
        check(irq == 0, "R8 irq after clear", irq, 0);

        // R5: ready run that wraps past the tail, resumed from saved pointer
        mem[32/4] = {1'b1, 31'h0000_0A5A};
        mem[48/4] = {1'b1, 31'h0000_0A5A};
        mem[0]    = {1'b1, 31'h0000_0A5A};
        expect_desc(32); expect_desc(48); expect_desc(0);
        run_walk();
        q_empty("R5 wrap records");
        check(cur_ptr == 32'h10, "R5 ptr after wrap", cur_ptr, 32'h10);
        check(irq == 1, "R7 irq after wrap", irq, 1);
        clear_irq();

        // R7: nothing ready, no record, pointer unchanged
        run_walk();
        q_empty("R3 empty walk");
        check(cur_ptr == 32'h10, "R5 ptr empty walk", cur_ptr, 32'h10);
        check(int_status == 1'b1, "R7 done on empty", int_status, 1);
        clear_irq();

        // R4: size word upper bits ignored; R10: go and ptr write while busy ignored
        build_ring(4'b1111);
        mem[1] = 32'hFFFF_F800 | 32'h7FF;
        mem[5] = 32'hABCD_E000 | 32'h040;
        set_ptr(32'h0);
        for (int i = 0; i < 4; i++) expect_desc(i*16);
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        repeat (5) @(negedge clk);
        go = 1; cur_wr = 1; cur_wdata = 32'h0F0;
        @(negedge clk); go = 0; cur_wr = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        q_empty("R10 full ring records");
        check(cur_ptr == 32'h0, "R10 ptr after full ring", cur_ptr, 0);
        check(busy == 0, "R10 no restart", busy, 0);
        check(mem[12] == 32'h0000_0A5A, "R6 writeback d3", mem[12], 32'h0000_0A5A);

        // R2: software load of pointer while idle starts from there
        build_ring(4'b0100);
        set_ptr(32'h20);
        check(cur_ptr == 32'h20, "R2 ptr load", cur_ptr, 32'h20);
        expect_desc(32);
        run_walk();
        q_empty("R2 start at ptr");
        check(cur_ptr == 32'h30, "R5 ptr after single", cur_ptr, 32'h30);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule